// File: doc/BRIEF.md
# Serial-Stream Complex Butterfly

This block performs one radix-2 butterfly step on complex fixed-point data delivered over a single narrow stream. Each input word carries one complex number: two signed two's-complement halves, real and imaginary. Words arrive in groups of three. The first is the upper operand, the second is the lower operand, and the third is the twiddle factor. Once the third word is taken, the block multiplies the lower operand by the twiddle. It then forms the sum and the difference with the upper operand, halves both, and sends the two results out one after the other on a single output stream.

Words may arrive with any number of idle cycles between them. A one-cycle valid strobe marks each word. A narrow side-band tag travels with each word and is re-timed onto the matching result. A separate debug port shows the intermediate values of every butterfly without disturbing the result stream. The block is meant to sit inside a larger transform engine, which provides the operand ordering and the twiddle values.

Top module: `serial_butterfly`

## Requirements
- R1: A word is `2*CW` bits wide. Bits `[2*CW-1:CW]` hold the real part and bits `[CW-1:0]` hold the imaginary part. Each part is signed two's complement with `CW-1` fraction bits.
- R2: Words count only in cycles where `in_valid` is high. They are taken in the order upper operand, lower operand, twiddle, and the fourth valid word starts a new group. Data and tag in cycles without `in_valid` have no effect on any result.
- R3: The first result Y0 is formed per component as follows. The lower operand is multiplied by the twiddle, and the result is truncated to `floor(x / 2^(CW-1))`. For the real part this is `floor((br*wr - bi*wi)/2^(CW-1))`; for the imaginary part it is `floor((br*wi + bi*wr)/2^(CW-1))`. This product P is added to the upper operand A, and the sum is halved with rounding toward minus infinity: Y0 = floor((A + P)/2).
- R4: The second result is Y1 = floor((A - P)/2), computed per component with the same P as in R3.
- R5: Y0 appears on the output three clock edges after the edge that takes the twiddle word. Y1 appears on the following edge. `out_valid` is high for exactly one cycle per result.
- R6: `out_valid` is high only for results of complete groups. An incomplete group produces nothing, and no result is lost or duplicated.
- R7: `out_tag` carries the upper operand's tag while Y0 is shown and the lower operand's tag while Y1 is shown. The twiddle's tag is discarded. `out_tag` is zero whenever `out_valid` is low.
- R8: `dbg_valid` pulses in the Y0 cycle. The debug port then shows floor(A/2), floor(P/2), Y0 and Y1, each packed as in R1. The result stream does not depend on the debug port.
- R9: A synchronous active-high `rst` clears `out_valid` and `dbg_valid`, drops any partial group and any results still in flight, and makes the next valid word an upper operand.
- R10: Groups whose words arrive on consecutive cycles, with no idle cycles, are processed with no loss. Each group still meets the timing of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 2*CW | Complex input word |
| in_tag | input | TW | Side-band tag of the input word |
| out_valid | output | 1 | Result word strobe |
| out_data | output | 2*CW | Complex result word (Y0, then Y1) |
| out_tag | output | TW | Tag re-timed to the result |
| dbg_valid | output | 1 | Debug record strobe, one per butterfly |
| dbg_a | output | 2*CW | Halved upper operand |
| dbg_bw | output | 2*CW | Halved twiddle product |
| dbg_y0 | output | 2*CW | Sum result |
| dbg_y1 | output | 2*CW | Difference result |

## Verification
When groups arrive with no idle cycles, the output stage must do two things in one cycle. It shows the held Y1 of one group while the capture stage takes the upper or lower operand of the next group. A later cycle also brings that next group's Y0 right after the earlier pair.

The bench provokes this overlap by sweeping idle gaps of zero to four cycles between words. It mixes in gap-free runs, and it resets the block while a group is in flight. Each result is compared to an arithmetic model, together with its tag, the exact cycle in which it is due, and the matching debug record. Any slip, any lost word, or any extra word therefore shows up as a mismatch.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [1:0] {
    SLOT_A = 2'd0,
    SLOT_B = 2'd1,
    SLOT_W = 2'd2
  } slot_e;

  function automatic slot_e next_slot(input slot_e cur);
    unique case (cur)
      SLOT_A:  return SLOT_B;
      SLOT_B:  return SLOT_W;
      default: return SLOT_A;
    endcase
  endfunction

endpackage

// File: rtl/sbf_capture.sv
module sbf_capture #(
  parameter int CW = 16,
  parameter int TW = 1,
  localparam int DW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [TW-1:0] in_tag,
  output logic          grp_valid,
  output logic [DW-1:0] grp_a,
  output logic [DW-1:0] grp_b,
  output logic [DW-1:0] grp_w,
  output logic [TW-1:0] grp_tag_a,
  output logic [TW-1:0] grp_tag_b
);
  import sbf_pkg::*;

  slot_e         slot_q;
  logic [DW-1:0] a_q, b_q;
  logic [TW-1:0] ta_q, tb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= SLOT_A;
      grp_valid <= 1'b0;
    end else begin
      grp_valid <= 1'b0;
      if (in_valid) begin
        slot_q <= next_slot(slot_q);
        unique case (slot_q)
          SLOT_A: begin
            a_q  <= in_data;
            ta_q <= in_tag;
          end
          SLOT_B: begin
            b_q  <= in_data;
            tb_q <= in_tag;
          end
          default: begin
            grp_valid <= 1'b1;
            grp_a     <= a_q;
            grp_b     <= b_q;
            grp_w     <= in_data;
            grp_tag_a <= ta_q;
            grp_tag_b <= tb_q;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sbf_cmul.sv
module sbf_cmul #(
  parameter int CW = 16,
  parameter int TW = 1,
  localparam int DW = 2 * CW,
  localparam int FRAC = CW - 1,
  localparam int PW = CW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grp_valid,
  input  logic [DW-1:0]   grp_a,
  input  logic [DW-1:0]   grp_b,
  input  logic [DW-1:0]   grp_w,
  input  logic [TW-1:0]   grp_tag_a,
  input  logic [TW-1:0]   grp_tag_b,
  output logic            m_valid,
  output logic [DW-1:0]   m_a,
  output logic [2*PW-1:0] m_bw,
  output logic [TW-1:0]   m_tag_a,
  output logic [TW-1:0]   m_tag_b
);

  logic signed [CW-1:0] br, bi, wr, wi;
  assign br = grp_b[DW-1:CW];
  assign bi = grp_b[CW-1:0];
  assign wr = grp_w[DW-1:CW];
  assign wi = grp_w[CW-1:0];

  logic signed [DW-1:0] p_rr, p_ii, p_ri, p_ir;
  assign p_rr = br * wr;
  assign p_ii = bi * wi;
  assign p_ri = br * wi;
  assign p_ir = bi * wr;

  logic signed [DW:0] acc_re, acc_im, sh_re, sh_im;
  assign acc_re = {p_rr[DW-1], p_rr} - {p_ii[DW-1], p_ii};
  assign acc_im = {p_ri[DW-1], p_ri} + {p_ir[DW-1], p_ir};
  assign sh_re  = acc_re >>> FRAC;
  assign sh_im  = acc_im >>> FRAC;

  logic unused_hi;
  assign unused_hi = ^{sh_re[DW:PW], sh_im[DW:PW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
    end else begin
      m_valid <= grp_valid;
    end
    if (grp_valid) begin
      m_a     <= grp_a;
      m_bw    <= {sh_re[PW-1:0], sh_im[PW-1:0]};
      m_tag_a <= grp_tag_a;
      m_tag_b <= grp_tag_b;
    end
  end

endmodule

// File: rtl/sbf_addsub.sv
module sbf_addsub #(
  parameter int CW = 16,
  parameter int TW = 1,
  localparam int DW = 2 * CW,
  localparam int PW = CW + 1,
  localparam int SW = CW + 2,
  localparam int LANES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            m_valid,
  input  logic [DW-1:0]   m_a,
  input  logic [2*PW-1:0] m_bw,
  input  logic [TW-1:0]   m_tag_a,
  input  logic [TW-1:0]   m_tag_b,
  output logic            s_valid,
  output logic [DW-1:0]   s_y0,
  output logic [DW-1:0]   s_y1,
  output logic [DW-1:0]   s_ha,
  output logic [DW-1:0]   s_hbw,
  output logic [TW-1:0]   s_tag_a,
  output logic [TW-1:0]   s_tag_b
);

  logic [DW-1:0] y0_c, y1_c, ha_c, hbw_c;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [CW-1:0] a_k;
    logic signed [PW-1:0] p_k;
    logic signed [SW-1:0] sum_k, dif_k;
    logic                 unused_k;

    assign a_k   = m_a[k*CW +: CW];
    assign p_k   = m_bw[k*PW +: PW];
    assign sum_k = {{2{a_k[CW-1]}}, a_k} + {p_k[PW-1], p_k};
    assign dif_k = {{2{a_k[CW-1]}}, a_k} - {p_k[PW-1], p_k};

    assign y0_c[k*CW +: CW]  = sum_k[CW:1];
    assign y1_c[k*CW +: CW]  = dif_k[CW:1];
    assign ha_c[k*CW +: CW]  = {a_k[CW-1], a_k[CW-1:1]};
    assign hbw_c[k*CW +: CW] = p_k[CW:1];

    assign unused_k = ^{sum_k[SW-1], sum_k[0], dif_k[SW-1], dif_k[0], a_k[0], p_k[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
    end else begin
      s_valid <= m_valid;
    end
    if (m_valid) begin
      s_y0    <= y0_c;
      s_y1    <= y1_c;
      s_ha    <= ha_c;
      s_hbw   <= hbw_c;
      s_tag_a <= m_tag_a;
      s_tag_b <= m_tag_b;
    end
  end

endmodule

// File: rtl/sbf_serializer.sv
module sbf_serializer #(
  parameter int CW = 16,
  parameter int TW = 1,
  localparam int DW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [DW-1:0] s_y0,
  input  logic [DW-1:0] s_y1,
  input  logic [DW-1:0] s_ha,
  input  logic [DW-1:0] s_hbw,
  input  logic [TW-1:0] s_tag_a,
  input  logic [TW-1:0] s_tag_b,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [TW-1:0] out_tag,
  output logic          dbg_valid,
  output logic [DW-1:0] dbg_a,
  output logic [DW-1:0] dbg_bw,
  output logic [DW-1:0] dbg_y0,
  output logic [DW-1:0] dbg_y1
);

  logic          pend_q;
  logic [DW-1:0] hold_q;
  logic [TW-1:0] hold_tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_tag   <= '0;
      dbg_valid <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_tag   <= '0;
      dbg_valid <= s_valid;
      if (s_valid) begin
        out_valid  <= 1'b1;
        out_data   <= s_y0;
        out_tag    <= s_tag_a;
        hold_q     <= s_y1;
        hold_tag_q <= s_tag_b;
        pend_q     <= 1'b1;
      end else if (pend_q) begin
        out_valid <= 1'b1;
        out_data  <= hold_q;
        out_tag   <= hold_tag_q;
        pend_q    <= 1'b0;
      end
    end
    if (s_valid) begin
      dbg_a  <= s_ha;
      dbg_bw <= s_hbw;
      dbg_y0 <= s_y0;
      dbg_y1 <= s_y1;
    end
  end

endmodule

// File: rtl/serial_butterfly.sv
module serial_butterfly #(
  parameter int CW = 16,
  parameter int TW = 1,
  localparam int DW = 2 * CW,
  localparam int PW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [TW-1:0] in_tag,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [TW-1:0] out_tag,
  output logic          dbg_valid,
  output logic [DW-1:0] dbg_a,
  output logic [DW-1:0] dbg_bw,
  output logic [DW-1:0] dbg_y0,
  output logic [DW-1:0] dbg_y1
);

  logic            grp_valid;
  logic [DW-1:0]   grp_a, grp_b, grp_w;
  logic [TW-1:0]   grp_tag_a, grp_tag_b;

  logic            m_valid;
  logic [DW-1:0]   m_a;
  logic [2*PW-1:0] m_bw;
  logic [TW-1:0]   m_tag_a, m_tag_b;

  logic            s_valid;
  logic [DW-1:0]   s_y0, s_y1, s_ha, s_hbw;
  logic [TW-1:0]   s_tag_a, s_tag_b;

  sbf_capture #(.CW(CW), .TW(TW)) u_capture (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_tag(in_tag),
    .grp_valid(grp_valid), .grp_a(grp_a), .grp_b(grp_b), .grp_w(grp_w),
    .grp_tag_a(grp_tag_a), .grp_tag_b(grp_tag_b)
  );

  sbf_cmul #(.CW(CW), .TW(TW)) u_cmul (
    .clk(clk), .rst(rst),
    .grp_valid(grp_valid), .grp_a(grp_a), .grp_b(grp_b), .grp_w(grp_w),
    .grp_tag_a(grp_tag_a), .grp_tag_b(grp_tag_b),
    .m_valid(m_valid), .m_a(m_a), .m_bw(m_bw),
    .m_tag_a(m_tag_a), .m_tag_b(m_tag_b)
  );

  sbf_addsub #(.CW(CW), .TW(TW)) u_addsub (
    .clk(clk), .rst(rst),
    .m_valid(m_valid), .m_a(m_a), .m_bw(m_bw),
    .m_tag_a(m_tag_a), .m_tag_b(m_tag_b),
    .s_valid(s_valid), .s_y0(s_y0), .s_y1(s_y1), .s_ha(s_ha), .s_hbw(s_hbw),
    .s_tag_a(s_tag_a), .s_tag_b(s_tag_b)
  );

  sbf_serializer #(.CW(CW), .TW(TW)) u_serializer (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_y0(s_y0), .s_y1(s_y1), .s_ha(s_ha), .s_hbw(s_hbw),
    .s_tag_a(s_tag_a), .s_tag_b(s_tag_b),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag),
    .dbg_valid(dbg_valid), .dbg_a(dbg_a), .dbg_bw(dbg_bw),
    .dbg_y0(dbg_y0), .dbg_y1(dbg_y1)
  );

endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int TW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [TW-1:0] out_tag,
  input logic          dbg_valid
);

  logic [1:0] ph_q;
  logic [4:0] hist_q;
  logic       w_take;

  assign w_take = in_valid && (ph_q == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= 2'd0;
      hist_q <= '0;
    end else begin
      if (in_valid) ph_q <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
      hist_q <= {hist_q[3:0], w_take};
    end
  end

  // R5
  y_timing_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == (hist_q[3] || hist_q[4]));

  // R8
  dbg_with_y0_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_valid |-> out_valid);

  // R5
  y1_follows_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_valid |=> (out_valid && !dbg_valid));

  // R7
  idle_tag_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_tag == '0));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !dbg_valid));

endmodule

bind serial_butterfly sbf_checker #(.TW(TW)) u_sbf_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_tag(out_tag), .dbg_valid(dbg_valid)
);

// File: tb/test_serial_butterfly.sv
module test_serial_butterfly;
  localparam int CW = 8;
  localparam int TW = 1;
  localparam int DW = 2 * CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [TW-1:0] in_tag = '0;
  logic          out_valid, dbg_valid;
  logic [DW-1:0] out_data, dbg_a, dbg_bw, dbg_y0, dbg_y1;
  logic [TW-1:0] out_tag;

  always #2.5 clk = ~clk;

  serial_butterfly #(.CW(CW), .TW(TW)) i_serial_butterfly (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_tag(in_tag),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag),
    .dbg_valid(dbg_valid), .dbg_a(dbg_a), .dbg_bw(dbg_bw),
    .dbg_y0(dbg_y0), .dbg_y1(dbg_y1)
  );

  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  int unsigned seed = 32'h1234_5678;
  bit          finished = 0;

  logic [DW-1:0] eq_d[$];
  logic [TW-1:0] eq_t[$];
  int unsigned   eq_c[$];
  logic [DW-1:0] dq_a[$], dq_bw[$], dq_y0[$], dq_y1[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int unsigned lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] pack(input int re, input int im);
    logic [DW-1:0] r;
    r[DW-1:CW] = re[CW-1:0];
    r[CW-1:0]  = im[CW-1:0];
    return r;
  endfunction

  // Arithmetic model built from R1, R3, R4 and R8.
  task automatic model(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] w,
                       output logic [DW-1:0] y0, output logic [DW-1:0] y1,
                       output logic [DW-1:0] ha, output logic [DW-1:0] hbw);
    int ar, ai, br, bi, wr, wi, pr, pi;
    ar = $signed(a[DW-1:CW]); ai = $signed(a[CW-1:0]);
    br = $signed(b[DW-1:CW]); bi = $signed(b[CW-1:0]);
    wr = $signed(w[DW-1:CW]); wi = $signed(w[CW-1:0]);
    pr = (br * wr - bi * wi) >>> (CW - 1);
    pi = (br * wi + bi * wr) >>> (CW - 1);
    y0  = pack((ar + pr) >>> 1, (ai + pi) >>> 1);
    y1  = pack((ar - pr) >>> 1, (ai - pi) >>> 1);
    ha  = pack(ar >>> 1, ai >>> 1);
    hbw = pack(pr >>> 1, pi >>> 1);
  endtask

  task automatic send_word(input logic [DW-1:0] d, input logic [TW-1:0] t, input int gap);
    in_valid = 1'b1;
    in_data  = d;
    in_tag   = t;
    @(negedge clk);
    in_valid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      in_data = lcg();        // R2: junk without strobe
      in_tag  = TW'(lcg());
      @(negedge clk);
    end
  endtask

  task automatic send_group(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] w,
                            input logic [TW-1:0] ta, input logic [TW-1:0] tb,
                            input logic [TW-1:0] tw, input int gap);
    logic [DW-1:0] y0, y1, ha, hbw;
    model(a, b, w, y0, y1, ha, hbw);
    send_word(a, ta, gap);
    send_word(b, tb, gap);
    // R5: W accepted at edge cyc+1, Y0 due at negedge with cyc+4
    eq_d.push_back(y0); eq_t.push_back(ta); eq_c.push_back(cyc + 4);
    eq_d.push_back(y1); eq_t.push_back(tb); eq_c.push_back(cyc + 5);
    dq_a.push_back(ha); dq_bw.push_back(hbw); dq_y0.push_back(y0); dq_y1.push_back(y1);
    send_word(w, tw, gap);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    eq_d.delete(); eq_t.delete(); eq_c.delete();
    dq_a.delete(); dq_bw.delete(); dq_y0.delete(); dq_y1.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!out_valid && !dbg_valid, "R9", "valids in reset", {out_valid, dbg_valid}, 0);
    end
    rst = 1'b0;
  endtask

  // Output monitor: R3, R4, R5, R6, R7, R8, R10
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (out_valid) begin
        if (eq_d.size() == 0) begin
          check(0, "R6", "unexpected out_valid", out_data, 0);
        end else begin
          check(out_data == eq_d[0], "R3", "result word", out_data, eq_d[0]);
          check(out_tag == eq_t[0], "R7", "result tag", out_tag, eq_t[0]);
          check(cyc == eq_c[0], "R5", "result cycle", cyc, eq_c[0]);
          void'(eq_d.pop_front()); void'(eq_t.pop_front()); void'(eq_c.pop_front());
        end
      end else if (eq_c.size() != 0 && cyc > eq_c[0]) begin
        check(0, "R6", "result missing", cyc, eq_c[0]);
        void'(eq_d.pop_front()); void'(eq_t.pop_front()); void'(eq_c.pop_front());
      end
      if (dbg_valid) begin
        if (dq_a.size() == 0) begin
          check(0, "R8", "unexpected dbg_valid", dbg_a, 0);
        end else begin
          check(dbg_a == dq_a[0], "R8", "dbg_a", dbg_a, dq_a[0]);
          check(dbg_bw == dq_bw[0], "R8", "dbg_bw", dbg_bw, dq_bw[0]);
          check(dbg_y0 == dq_y0[0], "R4", "dbg_y0", dbg_y0, dq_y0[0]);
          check(dbg_y1 == dq_y1[0], "R4", "dbg_y1", dbg_y1, dq_y1[0]);
          void'(dq_a.pop_front()); void'(dq_bw.pop_front());
          void'(dq_y0.pop_front()); void'(dq_y1.pop_front());
        end
      end
    end
  end

  function automatic int twid(input int v);
    return (v % 128) - 64;   // twiddle component kept within about +/-0.5
  endfunction

  initial begin
    @(negedge clk);
    do_reset(4);

    // Hand-picked extremes (R3, R4)
    send_group(pack(127, 127), pack(-128, -128), pack(-64, -64), 1, 0, 1, 4);
    send_group(pack(-128, -128), pack(127, -128), pack(63, -64), 0, 1, 1, 4);
    send_group(pack(0, 0), pack(0, 0), pack(0, 0), 1, 1, 0, 1);
    send_group(pack(-1, 1), pack(1, -1), pack(63, 63), 0, 0, 1, 2);
    repeat (10) @(negedge clk);

    // Sweep with gaps 0..4 (R2, R10)
    for (int i = 0; i < 256; i++) begin
      send_group(pack(i, 255 - i), pack(i * 37, i * 91), pack(twid(i), twid(i * 5 + 63)),
                 TW'(i), TW'(i >> 1), TW'(i >> 2), i % 5);
    end
    repeat (10) @(negedge clk);

    // Pseudo-random groups, back-to-back (R10)
    for (int i = 0; i < 300; i++) begin
      send_group(DW'(lcg()), DW'(lcg()), pack(twid(int'(lcg() % 1024)), twid(int'(lcg() % 1024))),
                 TW'(lcg()), TW'(lcg()), TW'(lcg()), (i % 7 == 0) ? 3 : 0);
    end
    repeat (10) @(negedge clk);

    // R9: partial group then reset, next word must be an upper operand
    send_word(pack(50, 50), 1, 0);
    send_word(pack(20, 20), 1, 0);
    do_reset(2);
    send_group(pack(10, -10), pack(100, 20), pack(40, -30), 1, 0, 0, 1);
    repeat (10) @(negedge clk);

    // R9: reset with results in flight, they must vanish
    send_group(pack(90, 90), pack(90, 90), pack(50, 50), 1, 1, 1, 0);
    do_reset(1);
    repeat (8) @(negedge clk);
    check(!out_valid, "R9", "no output after flush", out_valid, 0);
    send_group(pack(-7, 33), pack(-99, 12), pack(-60, 17), 0, 1, 1, 0);
    repeat (10) @(negedge clk);

    check(eq_d.size() == 0, "R6", "pending results", eq_d.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule